// File: doc/BRIEF.md
# Shared-Vector GPIO Interrupt Combiner

This block folds the interrupt requests of a bank of general-purpose pins into a single interrupt line. The pins are grouped into ports of eight. Each port carries one polarity bit that selects which logic level counts as a trigger for every pin in that port. Each pin has its own enable bit. A global enable gates the final request on its way to the interrupt priority logic.

Pins pass through a two-flop synchronizer first. The qualified triggers are then ORed together. A rising edge of that OR sets a pending flip-flop, and the controller's acknowledge clears it. No priority exists among the pins. The synchronized pin values are exported so that firmware can read the port data to find the pin that fired.

The trigger is a single OR of levels, which produces a lockout. While one enabled pin sits in its trigger state, a second pin that becomes active adds nothing. A new request can only come once the first pin leaves its trigger state or loses its enable.

Top module: `gpio_irq_combiner`

## Requirements
- R1: After reset, `irq_req` is 0 and `pin_sync` is all zeros.
- R2: `pin_sync` presents `pin_in` delayed by two clock edges.
- R3: A pin whose `pin_en` bit is 0 never causes a request, whatever its level.
- R4: `port_pol[p]` = 1 makes a high level the trigger state for all pins of port p (pins 8p..8p+7); 0 makes a low level the trigger state.
- R5: When the OR of enabled, polarity-qualified pins goes from 0 to 1, the pending flag sets. With `global_en` = 1, `irq_req` is high after the third rising clock edge following the pin change.
- R6: A one-cycle `irq_ack` clears the pending flag. A trigger level that is still held afterwards does not raise a new request.
- R7: While one enabled pin is in its trigger state, another enabled pin entering its trigger state raises no request.
- R8: Once the blocking pin goes inactive, or its enable is cleared, a later trigger from another pin raises a request again.
- R9: With `global_en` = 0, `irq_req` stays 0 while the pending flag can still set. Setting `global_en` then shows the stored request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PORTS*PORT_W | Asynchronous pin levels |
| port_pol | input | NUM_PORTS | Per-port trigger polarity, 1 = high active |
| pin_en | input | NUM_PORTS*PORT_W | Per-pin interrupt enable |
| global_en | input | 1 | Global GPIO interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears pending |
| irq_req | output | 1 | Request to the priority logic |
| pin_sync | output | NUM_PORTS*PORT_W | Synchronized pin data for firmware reads |

## Verification
The bench holds one pin active and then activates a second one. A design that ORed edges per pin instead of levels would fire a second time there. It also holds a level across an acknowledge, which catches a level-set pending flag that re-requests at once. The stimulus includes a masked pin toggling and a polarity flip on the second port only; a wrong port index or an inverted polarity shows up as a spurious or missing request. Finally, it lets a request become pending with the global enable clear and then raises the enable, separating a gate placed before the flip-flop from one placed after it.

// File: rtl/gpio_irq_combiner.sv
module gpio_irq_combiner #(
  parameter int NUM_PORTS = 2,
  parameter int PORT_W    = 8,
  localparam int N        = NUM_PORTS * PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         pin_in,
  input  logic [NUM_PORTS-1:0] port_pol,
  input  logic [N-1:0]         pin_en,
  input  logic                 global_en,
  input  logic                 irq_ack,
  output logic                 irq_req,
  output logic [N-1:0]         pin_sync
);

  logic [N-1:0] meta, stab, pol_x;
  logic         trig, trig_q, pend;

  for (genvar i = 0; i < N; i++) begin : g_pol
    assign pol_x[i] = port_pol[i / PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      stab <= '0;
    end else begin
      meta <= pin_in;
      stab <= meta;
    end
  end

  assign trig = |((stab ~^ pol_x) & pin_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (trig && !trig_q) pend <= 1'b1;
      else if (irq_ack)    pend <= 1'b0;
    end
  end

  assign irq_req  = pend & global_en;
  assign pin_sync = stab;

endmodule

// File: rtl/gpio_irq_combiner_chk.sv
module gpio_irq_combiner_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_en,
  input logic         global_en,
  input logic         irq_ack,
  input logic         irq_req,
  input logic         trig,
  input logic         trig_q,
  input logic         pend
);

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !global_en |-> !irq_req);

  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !trig_q) |=> pend);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(trig && !trig_q)) |=> !pend);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(trig && !trig_q)) |=> !pend);

  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) |-> !trig);

endmodule

bind gpio_irq_combiner gpio_irq_combiner_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .global_en(global_en),
  .irq_ack(irq_ack), .irq_req(irq_req), .trig(trig), .trig_q(trig_q),
  .pend(pend)
);

// File: tb/gpio_irq_combiner_bench.sv
`timescale 1ns/1ps
module gpio_irq_combiner_bench;
  localparam int NP = 2;
  localparam int W  = 8;
  localparam int N  = NP * W;

  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  pin_in = '0, pin_en = '0;
  logic [NP-1:0] port_pol = '1;
  logic          global_en = 0, irq_ack = 0;
  logic          irq_req;
  logic [N-1:0]  pin_sync;

  gpio_irq_combiner #(.NUM_PORTS(NP), .PORT_W(W)) u_gpio_irq_combiner (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_pol(port_pol),
    .pin_en(pin_en), .global_en(global_en), .irq_ack(irq_ack),
    .irq_req(irq_req), .pin_sync(pin_sync));

  always #4 clk = ~clk;

  typedef struct {
    int           due;
    bit           req;
    bit           use_sync;
    logic [N-1:0] sync;
    string        tag;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (irq_req !== it.req) begin
          errors++;
          $display("FAIL %s: irq_req=%0b expected %0b", it.tag, irq_req, it.req);
        end
        if (it.use_sync) begin
          checks++;
          if (pin_sync !== it.sync) begin
            errors++;
            $display("FAIL %s: pin_sync=%h expected %h", it.tag, pin_sync, it.sync);
          end
        end
      end
    end
  end

  task automatic drv();
    @(negedge clk); #1;
  endtask

  task automatic expect_req(int d, bit r, string tag);
    item_t it;
    it.due = cyc + d; it.req = r; it.use_sync = 0; it.sync = '0; it.tag = tag;
    q.push_back(it);
    repeat (d + 1) @(negedge clk);
  endtask

  task automatic expect_all(int d, bit r, logic [N-1:0] s, string tag);
    item_t it;
    it.due = cyc + d; it.req = r; it.use_sync = 1; it.sync = s; it.tag = tag;
    q.push_back(it);
    repeat (d + 1) @(negedge clk);
  endtask

  task automatic ack();
    drv(); irq_ack = 1;
    drv(); irq_ack = 0;
  endtask

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_all(0, 0, '0, "R1 reset state");
    drv(); rst_n = 1;

    drv(); global_en = 1; pin_en = 16'h0003; pin_in = 16'h0020;
    expect_all(3, 0, 16'h0020, "R3 R2 disabled pin, sync data");
    drv(); pin_in = 16'h0000;
    expect_req(3, 0, "R3 disabled pin release");

    drv(); pin_in = 16'h0001;
    expect_req(3, 1, "R5 pin0 raises request");

    ack();
    expect_req(4, 0, "R6 held level after ack");

    drv(); pin_in = 16'h0003;
    expect_req(4, 0, "R7 second pin locked out");

    drv(); pin_in = 16'h0002;
    expect_req(3, 0, "R7 first pin drops, second still holds");
    drv(); pin_in = 16'h0000;
    expect_req(3, 0, "R8 all inactive");
    drv(); pin_in = 16'h0002;
    expect_req(3, 1, "R8 retrigger after release");
    ack();
    expect_req(1, 0, "R6 ack clears");

    drv(); pin_in = 16'h0003;
    expect_req(3, 0, "R7 pin0 joins held pin1");
    drv(); pin_en = 16'h0001; pin_in = 16'h0002;
    expect_req(3, 0, "R8 blocking pin enable cleared");
    drv(); pin_in = 16'h0003;
    expect_req(3, 1, "R8 retrigger after enable clear");
    ack();

    drv(); pin_in = 16'h0000; global_en = 0;
    expect_req(3, 0, "R9 idle, masked");
    drv(); pin_in = 16'h0001;
    expect_req(4, 0, "R9 pending but masked");
    drv(); global_en = 1;
    expect_req(0, 1, "R9 stored request shown on enable");
    ack();
    drv(); pin_in = 16'h0000;
    expect_req(3, 0, "R6 clear before polarity test");

    drv(); pin_en = 16'h0101;
    expect_req(3, 0, "R4 low pins not active with pol=1");
    drv(); port_pol = 2'b01;
    expect_req(3, 1, "R4 port1 active-low triggers pin8");
    ack();
    drv(); pin_in = 16'h0100;
    expect_req(3, 0, "R4 pin8 high inactive on port1");
    drv(); pin_in = 16'h0000;
    expect_req(3, 1, "R4 pin8 low retriggers");
    ack();
    expect_req(1, 0, "R6 final ack");

    drv(); done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule